// File: doc/BRIEF.md
# Fractional 100 Hz Tick Generator

This block turns a 4096 Hz enable strobe into a 100 Hz tick. 4096 is not a whole multiple of 100, so no single integer divider fits. The block uses two divide ratios in a fixed group of 25 tick periods instead. The first 24 periods of each group last 41 reference pulses and the last one lasts 40. That makes 1024 reference pulses per 25 ticks, so the ticks are exact at every group boundary (every quarter second), and each single tick period is a little long or a little short.

A stop input is active high and works as an oscillator enable written in negative sense. While it is set, reference pulses have no effect and every counter holds its value. When it is released, counting continues from the same point in the group. Each tick also advances a two-digit BCD hundredths counter. That counter wraps from 99 to 00 with a one-cycle carry, and it shows a flag for as long as it holds 99.

Top module: `frac_tick_100hz`

## Requirements
- R1: After reset, `tick_100hz` and `hund_carry` are 0, `hund_bcd` is 8'h00, `hund_at_max` is 0, and the group position is the first long period.
- R2: Within a group, each of the first 24 tick periods spans 41 accepted reference pulses. `tick_100hz` goes high in the clock cycle right after the accepted pulse that completes the period.
- R3: The 25th period of each group spans 40 accepted reference pulses. After it, the pattern restarts with a long period.
- R4: Counted from reset, exactly 25 ticks occur in every 1024 accepted reference pulses. The tick falls after accepted pulse p (1-based within its group of 1024) when p is a multiple of 41 not above 984, or when p is 1024.
- R5: `tick_100hz` is high for exactly one clock cycle per tick and is never high in two consecutive cycles.
- R6: While `osc_stop` is 1, a reference pulse is ignored: no tick follows, `hund_bcd` does not change, and once `osc_stop` returns to 0 the tick pattern continues from where it stopped.
- R7: `hund_bcd` holds two BCD digits, tens in bits 7:4 and units in bits 3:0, each 0 to 9. It advances by one in decimal in the cycle after each tick and holds otherwise.
- R8: When a tick arrives while `hund_bcd` is 8'h99, the counter becomes 8'h00 and `hund_carry` is high for that one cycle only.
- R9: `hund_at_max` is 1 exactly when `hund_bcd` is 8'h99.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_en | input | 1 | One-cycle 4096 Hz reference strobe |
| osc_stop | input | 1 | When 1, reference strobes are ignored and all counters hold |
| tick_100hz | output | 1 | One-cycle 100 Hz strobe |
| hund_bcd | output | 4*NDIGITS (8) | BCD hundredths count, tens in the upper nibble |
| hund_carry | output | 1 | One-cycle pulse on the wrap from 99 to 00 |
| hund_at_max | output | 1 | High while the count holds 99 |

## Verification
The bench runs more than four full groups of 1024 reference pulses. After each accepted pulse it predicts the tick from the pulse's position in its group, so it checks the length of every long and short period. If the short period were in the wrong place, or 41 were used for all 25 periods, ticks would arrive one pulse late from the 25th tick on. The sweep also takes the hundredths counter through more than one wrap. A counter that skipped the BCD digit adjust would show 0A, and a carry timed wrongly would appear next to a nonzero count. Windows of stopped pulses are placed at many points of the group, including on period boundaries. A design that let a stopped pulse through, or that cleared its phase while stopped, would move every later tick.

// File: rtl/tick_pkg.sv
package tick_pkg;
   typedef logic [3:0] bcd_digit_t;
   localparam bcd_digit_t BCD_TOP = 4'd9;
endpackage

// File: rtl/frac_divider.sv
module frac_divider #(
   parameter int LONG_DIV  = 41,
   parameter int SHORT_DIV = 40,
   parameter int LONG_RUNS = 24
) (
   input  logic clk,
   input  logic rst_n,
   input  logic step,
   output logic tick
);
   localparam int GROUP = LONG_RUNS + 1;
   localparam int CW    = $clog2(LONG_DIV);
   localparam int PW    = (GROUP > 1) ? $clog2(GROUP) : 1;
   localparam logic [CW-1:0] LONG_END  = CW'(LONG_DIV - 1);
   localparam logic [CW-1:0] SHORT_END = CW'(SHORT_DIV - 1);
   localparam logic [PW-1:0] LAST_PH   = PW'(LONG_RUNS);

   if (SHORT_DIV < 2 || SHORT_DIV >= LONG_DIV) begin : g_bad_ratio
      $error("frac_divider: SHORT_DIV must be at least 2 and below LONG_DIV");
   end
   if (LONG_RUNS < 1) begin : g_bad_runs
      $error("frac_divider: LONG_RUNS must be at least 1");
   end

   logic [CW-1:0] cyc_q;
   logic [PW-1:0] phase_q;
   logic          tick_q;
   logic [CW-1:0] period_end;
   logic          at_end;

   always_comb begin
      period_end = (phase_q == LAST_PH) ? SHORT_END : LONG_END;
      at_end     = (cyc_q == period_end);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cyc_q   <= '0;
         phase_q <= '0;
         tick_q  <= 1'b0;
      end else begin
         tick_q <= 1'b0;
         if (step) begin
            if (at_end) begin
               cyc_q   <= '0;
               tick_q  <= 1'b1;
               phase_q <= (phase_q == LAST_PH) ? '0 : phase_q + 1'b1;
            end else begin
               cyc_q <= cyc_q + 1'b1;
            end
         end
      end
   end

   assign tick = tick_q;

   assert_cyc_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_q <= LONG_END);
   assert_phase_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      phase_q <= LAST_PH);
   assert_long_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (step && phase_q < LAST_PH && cyc_q == LONG_END) |=> (tick && cyc_q == '0));
   assert_short_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (step && phase_q == LAST_PH && cyc_q == SHORT_END) |=> (tick && phase_q == '0));
   assert_single_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);
   assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !step |=> ($stable(cyc_q) && $stable(phase_q) && !tick));
endmodule

// File: rtl/bcd_digit.sv
module bcd_digit
   import tick_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       inc,
   output bcd_digit_t val,
   output logic       at_top
);
   bcd_digit_t val_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   val_q <= '0;
      else if (inc) val_q <= (val_q == BCD_TOP) ? '0 : val_q + 1'b1;
   end

   assign val    = val_q;
   assign at_top = (val_q == BCD_TOP);

   assert_digit_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
      val_q <= BCD_TOP);
   assert_digit_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !inc |=> $stable(val_q));
endmodule

// File: rtl/hund_counter.sv
module hund_counter
   import tick_pkg::*;
#(
   parameter int NDIGITS = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 adv,
   output logic [4*NDIGITS-1:0] count,
   output logic                 carry,
   output logic                 at_max
);
   if (NDIGITS < 1) begin : g_bad_digits
      $error("hund_counter: NDIGITS must be at least 1");
   end

   logic [NDIGITS:0]   ripple;
   logic [NDIGITS-1:0] top_flags;
   logic               carry_q;

   assign ripple[0] = adv;

   for (genvar d = 0; d < NDIGITS; d++) begin : g_digit
      bcd_digit u_digit (
         .clk    (clk),
         .rst_n  (rst_n),
         .inc    (ripple[d]),
         .val    (count[4*d +: 4]),
         .at_top (top_flags[d])
      );
      assign ripple[d+1] = ripple[d] & top_flags[d];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) carry_q <= 1'b0;
      else        carry_q <= ripple[NDIGITS];
   end

   assign carry  = carry_q;
   assign at_max = &top_flags;

   assert_carry_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      carry |-> (count == '0));
   assert_carry_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      carry |=> !carry);
   assert_advance_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !at_max) |=> (count != $past(count)));
   assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !adv |=> ($stable(count) && !carry));
endmodule

// File: rtl/frac_tick_100hz.sv
module frac_tick_100hz #(
   parameter int LONG_DIV  = 41,
   parameter int SHORT_DIV = 40,
   parameter int LONG_RUNS = 24,
   parameter int NDIGITS   = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 ref_en,
   input  logic                 osc_stop,
   output logic                 tick_100hz,
   output logic [4*NDIGITS-1:0] hund_bcd,
   output logic                 hund_carry,
   output logic                 hund_at_max
);
   logic step;
   logic tick_w;

   assign step = ref_en & ~osc_stop;

   frac_divider #(
      .LONG_DIV  (LONG_DIV),
      .SHORT_DIV (SHORT_DIV),
      .LONG_RUNS (LONG_RUNS)
   ) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .step  (step),
      .tick  (tick_w)
   );

   hund_counter #(
      .NDIGITS (NDIGITS)
   ) u_hund (
      .clk    (clk),
      .rst_n  (rst_n),
      .adv    (tick_w),
      .count  (hund_bcd),
      .carry  (hund_carry),
      .at_max (hund_at_max)
   );

   assign tick_100hz = tick_w;

   assert_stop_no_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (osc_stop || !ref_en) |=> !tick_100hz);
endmodule

// File: tb/frac_tick_100hz_tb_top.sv
module frac_tick_100hz_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ref_en = 1'b0;
   logic       osc_stop = 1'b0;
   logic       tick_100hz;
   logic [7:0] hund_bcd;
   logic       hund_carry;
   logic       hund_at_max;

   int n_cmp  = 0;
   int n_bad  = 0;
   int n_acc  = 0;
   int hund_m = 0;
   int n_tick = 0;

   always #2 clk = ~clk;

   frac_tick_100hz dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .ref_en      (ref_en),
      .osc_stop    (osc_stop),
      .tick_100hz  (tick_100hz),
      .hund_bcd    (hund_bcd),
      .hund_carry  (hund_carry),
      .hund_at_max (hund_at_max)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h (pulse %0d)", req, act, exp, n_acc);
      end
   endtask

   function automatic bit tick_due(input int n);
      int p;
      p = ((n - 1) % 1024) + 1;
      return (p <= 984 && (p % 41) == 0) || (p == 1024);
   endfunction

   function automatic int to_bcd(input int h);
      return ((h / 10) << 4) | (h % 10);
   endfunction

   task automatic pulse(input bit stop);
      bit exp_tick;
      bit exp_carry;
      @(negedge clk);
      ref_en   = 1'b1;
      osc_stop = stop;
      @(negedge clk);
      ref_en   = 1'b0;
      osc_stop = 1'b0;
      exp_tick = 1'b0;
      if (!stop) begin
         n_acc++;
         exp_tick = tick_due(n_acc);
      end
      if (stop) chk("R6 tick after stopped pulse", tick_100hz, 0);
      else if (n_acc % 1024 > 984 || n_acc % 1024 == 0)
         chk("R3 short period tick", tick_100hz, exp_tick);
      else chk("R2 long period tick", tick_100hz, exp_tick);
      exp_carry = 1'b0;
      if (exp_tick) begin
         n_tick++;
         if (hund_m == 99) exp_carry = 1'b1;
         hund_m = (hund_m + 1) % 100;
      end
      @(negedge clk);
      chk("R5 tick one cycle wide", tick_100hz, 0);
      if (stop) chk("R6 count held while stopped", hund_bcd, to_bcd(hund_m));
      else      chk("R7 hundredths BCD count", hund_bcd, to_bcd(hund_m));
      chk("R8 wrap carry", hund_carry, exp_carry);
      chk("R9 at-max flag", hund_at_max, hund_m == 99);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 reset tick", tick_100hz, 0);
      chk("R1 reset count", hund_bcd, 0);
      chk("R1 reset carry", hund_carry, 0);
      chk("R1 reset at-max", hund_at_max, 0);
      rst_n = 1'b1;
      @(negedge clk);
      for (int i = 0; i < 4300; i++) begin
         if ((i % 89) < 3 && i > 0) pulse(1'b1);
         pulse(1'b0);
         if ((n_acc % 1024) == 0) begin
            chk("R4 ticks per 1024 pulses", n_tick, (n_acc / 1024) * 25);
         end
      end
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule